// File: doc/BRIEF.md
# DMA Event-to-Channel Scheduler

This block sits in front of a DMA engine and decides which channel is served next. Requests reach a channel by two routes. A hardware request line raises a pulse, and a per-source channel table fans that pulse out to any set of channels. Software can also write a one-hot start word. A channel that gets a request becomes pending. Among the pending channels that have a non-zero priority and are not halted, the block grants exactly one at a time. The highest priority wins, and on a tie the lowest channel number wins.

The grant is presented as a channel number with a valid flag. It stays in place until the engine returns a done pulse. The done pulse retires the channel and records a completion flag for it. A request that hits a channel already pending or in service is not queued; it marks an overflow error for that channel instead. A small word-wide register port gives software access to the priorities, the source tables, the halt control and the status vectors.

Top module: `dma_event_sched`

## Requirements
- R1: After reset every status vector (start, event-pending, stop, completion, error), the error mask, all priorities and all source tables read 0, and grantValid is 0.
- R2: A pulse on request line s sets the event-pending bit of every channel whose bit is 1 in the table at address 0x40+s. Several lines may target the same channel, and the pending bits read back at address 0x01.
- R3: A channel whose 3-bit priority (address 0x20+ch, bits 2:0) is 0 is never granted, even while it is pending.
- R4: Among eligible channels the one with the largest priority value is granted first. Among channels of equal priority, the lowest channel number is granted first.
- R5: A hardware or software request for a channel that is already pending, or currently granted, sets that channel's bit in the error register (address 0x05). It adds no second pending request.
- R6: Writing a word to the start register (address 0x00) marks each channel whose bit is 1 as software-pending, and that register reads back the software-pending bits.
- R7: A grant holds its channel number until a done pulse arrives. On the done pulse the channel's pending bits clear, its bit in the completion register (address 0x04) sets, and grantValid falls on the next cycle.
- R8: Writing 1 to a bit of the event-pending (0x01), stop (0x02) or completion (0x04) register clears that bit; bits written with 0 keep their value.
- R9: Writing 1 to a channel's bit of the halt register (address 0x03) sets its stop bit and removes its pending requests. A grant on that channel falls within two cycles, and a stopped channel is not granted until its stop bit is cleared.
- R10: The error register is read-only and clears when read. errIrq is 1 while any error bit is set whose bit in the mask register (address 0x06) is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 32 | Hardware request lines, one pulse per request |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (needed for clear-on-read) |
| regAddr | input | 7 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, same cycle |
| doneIn | input | 1 | Done pulse from the channel being served |
| grantValid | output | 1 | A channel is granted |
| grantChan | output | 5 | Granted channel number |
| errIrq | output | 1 | Masked overflow error interrupt |
| doneIrq | output | 1 | Any completion bit set |

## Verification
A corrupt pending vector shows up at the grant port on the next clock edge. Either a channel that was never requested is granted, or a requested channel is skipped in the priority order. A scoreboard of expected grant numbers catches both as soon as grantValid rises. A lost retire or a held stop bit leaves grantValid stuck or silent, and the next sequenced grant then never appears. A bad error or completion vector is visible on errIrq and doneIrq in the cycle after the request or done, and on the register reads that follow.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int CH_IDX_W = 5;
  localparam int IDX_W    = 5;
  localparam int ADDR_W   = 7;

  localparam logic [1:0] REGION_CTRL = 2'd0;
  localparam logic [1:0] REGION_PRIO = 2'd1;
  localparam logic [1:0] REGION_MASK = 2'd2;

  localparam logic [IDX_W-1:0] OFS_START = 5'd0;
  localparam logic [IDX_W-1:0] OFS_PEND  = 5'd1;
  localparam logic [IDX_W-1:0] OFS_STOP  = 5'd2;
  localparam logic [IDX_W-1:0] OFS_HALT  = 5'd3;
  localparam logic [IDX_W-1:0] OFS_INT   = 5'd4;
  localparam logic [IDX_W-1:0] OFS_ERR   = 5'd5;
  localparam logic [IDX_W-1:0] OFS_EMASK = 5'd6;

  // control -> datapath strobes
  typedef struct packed {
    logic                retire;
    logic [CH_IDX_W-1:0] chan;
  } arbStrobe_t;
endpackage

// File: rtl/dma_sched_regs.sv
module dma_sched_regs
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqIn,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWrData,
  output logic [DATA_W-1:0]        regRdData,
  input  arbStrobe_t               strobe,
  output logic [NUM_CH-1:0]        eligible,
  output logic [NUM_CH*PRIO_W-1:0] prioFlat,
  output logic                     errIrq,
  output logic                     doneIrq
);
  logic [NUM_CH-1:0] evPend, swStart, stopStat, intStat, errStat, errMask;
  logic [PRIO_W-1:0] prio [NUM_CH];
  logic [NUM_CH-1:0] srcMask [NUM_SRC];

  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             ctrlWr;
  logic [NUM_CH-1:0] wrBits, hitHw, swWr, haltWr, pendClr, stopClr, intClr;
  logic [NUM_CH-1:0] retireVec, pending, ovf;
  logic             errRdClr;

  assign region  = regAddr[ADDR_W-1:IDX_W];
  assign idx     = regAddr[IDX_W-1:0];
  assign ctrlWr  = regWrEn && (region == REGION_CTRL);
  assign wrBits  = regWrData[NUM_CH-1:0];
  assign swWr    = (ctrlWr && idx == OFS_START) ? wrBits : '0;
  assign haltWr  = (ctrlWr && idx == OFS_HALT)  ? wrBits : '0;
  assign pendClr = (ctrlWr && idx == OFS_PEND)  ? wrBits : '0;
  assign stopClr = (ctrlWr && idx == OFS_STOP)  ? wrBits : '0;
  assign intClr  = (ctrlWr && idx == OFS_INT)   ? wrBits : '0;
  assign errRdClr = regRdEn && (region == REGION_CTRL) && (idx == OFS_ERR);

  assign retireVec = strobe.retire ? (NUM_CH'(1) << strobe.chan) : '0;
  assign pending   = evPend | swStart;
  assign ovf       = (hitHw | swWr) & pending;

  // fan-out of hardware lines through the per-source tables
  always_comb begin
    hitHw = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (reqIn[s]) hitHw = hitHw | srcMask[s];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign prioFlat[c*PRIO_W +: PRIO_W] = prio[c];
    assign eligible[c] = pending[c] && (prio[c] != '0) && !stopStat[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evPend   <= '0;
      swStart  <= '0;
      stopStat <= '0;
      intStat  <= '0;
      errStat  <= '0;
      errMask  <= '0;
      for (int c = 0; c < NUM_CH; c++) prio[c] <= '0;
      for (int s = 0; s < NUM_SRC; s++) srcMask[s] <= '0;
    end else begin
      evPend   <= ((evPend & ~pendClr & ~retireVec) | (hitHw & ~pending)) & ~haltWr;
      swStart  <= ((swStart & ~retireVec) | (swWr & ~pending)) & ~haltWr;
      stopStat <= (stopStat & ~stopClr) | haltWr;
      intStat  <= (intStat & ~intClr) | retireVec;
      errStat  <= (errRdClr ? '0 : errStat) | ovf;
      if (ctrlWr && idx == OFS_EMASK) errMask <= wrBits;
      if (regWrEn && region == REGION_PRIO && int'(idx) < NUM_CH)
        prio[idx] <= regWrData[PRIO_W-1:0];
      if (regWrEn && region == REGION_MASK && int'(idx) < NUM_SRC)
        srcMask[idx] <= wrBits;
    end
  end

  always_comb begin
    regRdData = '0;
    case (region)
      REGION_CTRL: begin
        case (idx)
          OFS_START: regRdData = DATA_W'(swStart);
          OFS_PEND:  regRdData = DATA_W'(evPend);
          OFS_STOP:  regRdData = DATA_W'(stopStat);
          OFS_INT:   regRdData = DATA_W'(intStat);
          OFS_ERR:   regRdData = DATA_W'(errStat);
          OFS_EMASK: regRdData = DATA_W'(errMask);
          default:   regRdData = '0;
        endcase
      end
      REGION_PRIO: if (int'(idx) < NUM_CH)  regRdData = DATA_W'(prio[idx]);
      REGION_MASK: if (int'(idx) < NUM_SRC) regRdData = DATA_W'(srcMask[idx]);
      default:     regRdData = '0;
    endcase
  end

  assign errIrq  = |(errStat & errMask);
  assign doneIrq = |intStat;

  assert_overflow_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ovf != '0) |=> ((errStat & $past(ovf)) == $past(ovf)));

  assert_halt_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (haltWr != '0) |=> (((evPend | swStart) & $past(haltWr)) == '0));

  assert_retire_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire |=> ((intStat & $past(retireVec)) != '0));
endmodule

// File: rtl/dma_sched_arb.sv
module dma_sched_arb
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int PRIO_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        eligible,
  input  logic [NUM_CH*PRIO_W-1:0] prioFlat,
  input  logic                     doneIn,
  output logic                     grantValid,
  output logic [CH_IDX_W-1:0]      grantChan,
  output arbStrobe_t               strobe
);
  logic [PRIO_W-1:0]   bestPrio;
  logic [CH_IDX_W-1:0] bestChan;
  logic                anyElig;

  // scan downward so that on equal priority the lower index overwrites
  always_comb begin
    bestPrio = '0;
    bestChan = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (eligible[c] && prioFlat[c*PRIO_W +: PRIO_W] >= bestPrio) begin
        bestPrio = prioFlat[c*PRIO_W +: PRIO_W];
        bestChan = CH_IDX_W'(c);
      end
    end
  end
  assign anyElig = |eligible;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantChan  <= '0;
    end else if (!grantValid) begin
      if (anyElig) begin
        grantValid <= 1'b1;
        grantChan  <= bestChan;
      end
    end else if (doneIn || !eligible[grantChan]) begin
      grantValid <= 1'b0;
    end
  end

  assign strobe.retire = grantValid && doneIn;
  assign strobe.chan   = grantChan;

  assert_grant_eligible_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> (|(($past(eligible) >> grantChan) & NUM_CH'(1))));

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !doneIn && eligible[grantChan]) |=> (grantValid && $stable(grantChan)));

  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && doneIn) |=> !grantValid);

  assert_withdraw_R9: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !eligible[grantChan]) |=> !grantValid);
endmodule

// File: rtl/dma_event_sched.sv
module dma_event_sched
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  reqIn,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic                doneIn,
  output logic                grantValid,
  output logic [CH_IDX_W-1:0] grantChan,
  output logic                errIrq,
  output logic                doneIrq
);
  logic [NUM_CH-1:0]        eligible;
  logic [NUM_CH*PRIO_W-1:0] prioFlat;
  arbStrobe_t               strobe;

  dma_sched_regs #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .eligible(eligible), .prioFlat(prioFlat),
    .errIrq(errIrq), .doneIrq(doneIrq)
  );

  dma_sched_arb #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rstN(rstN), .eligible(eligible), .prioFlat(prioFlat),
    .doneIn(doneIn), .grantValid(grantValid), .grantChan(grantChan),
    .strobe(strobe)
  );
endmodule

// File: tb/dma_event_sched_tb.sv
module dma_event_sched_tb;
  localparam logic [6:0] A_START = 7'h00, A_PEND = 7'h01, A_STOP = 7'h02, A_HALT = 7'h03,
                         A_INT = 7'h04, A_ERR = 7'h05, A_EMASK = 7'h06;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqIn = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        doneIn = 1'b0;
  logic        grantValid;
  logic [4:0]  grantChan;
  logic        errIrq, doneIrq;

  int total = 0, bad = 0;
  bit finished = 0;
  int expQ[$];
  logic prevGv = 1'b0;

  always #4 clk = ~clk;

  dma_event_sched u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .doneIn(doneIn),
    .grantValid(grantValid), .grantChan(grantChan), .errIrq(errIrq), .doneIrq(doneIrq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 chk(regRdData === exp, tag, regRdData, exp);
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] lines);
    @(negedge clk); reqIn = lines;
    @(negedge clk); reqIn = '0;
  endtask

  task automatic serve();
    do @(negedge clk); while (!grantValid);
    doneIn = 1'b1;
    @(negedge clk); doneIn = 1'b0;
  endtask

  // monitor: every new grant must match the next scoreboard entry (R4)
  always @(negedge clk) begin
    if (rstN && grantValid && !prevGv) begin
      if (expQ.size() == 0) chk(1'b0, "R4 unexpected grant", 32'(grantChan), 32'hFFFF_FFFF);
      else begin
        int e;
        e = expQ.pop_front();
        chk(32'(grantChan) == 32'(e), "R4 grant order", 32'(grantChan), 32'(e));
      end
    end
    prevGv <= grantValid;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(grantValid === 1'b0, "R1 grantValid", 32'(grantValid), 0);
    rdChk(A_START, 0, "R1 start");
    rdChk(A_PEND, 0, "R1 pend");
    rdChk(A_STOP, 0, "R1 stop");
    rdChk(A_INT, 0, "R1 int");
    rdChk(A_ERR, 0, "R1 err");
    rdChk(A_EMASK, 0, "R1 emask");
    rdChk(7'h25, 0, "R1 prio");
    rdChk(7'h41, 0, "R1 srcmask");

    // setup: prio ch3=2, ch7=5, ch9=5, ch12=0
    wr(7'h23, 2); wr(7'h27, 5); wr(7'h29, 5);
    wr(7'h40, 32'h0000_1088);   // src0 -> ch3, ch7, ch12
    wr(7'h41, 32'h0000_0200);   // src1 -> ch9
    wr(7'h42, 32'h0000_0080);   // src2 -> ch7
    wr(A_EMASK, 32'h80);
    expQ.push_back(7); expQ.push_back(9); expQ.push_back(3);

    pulse(32'h3);                            // R2 fan-out
    rdChk(A_PEND, 32'h1288, "R2 fan-out pending");
    chk(grantValid && grantChan == 7, "R4 tie lowest index", 32'(grantChan), 7);

    pulse(32'h4);                            // R5 overflow on served ch7
    @(negedge clk);
    chk(errIrq === 1'b1, "R10 errIrq", 32'(errIrq), 1);
    rdChk(A_PEND, 32'h1288, "R5 no queueing");
    rdChk(A_ERR, 32'h80, "R5 overflow bit");
    rdChk(A_ERR, 32'h0, "R10 clear on read");
    chk(errIrq === 1'b0, "R10 errIrq cleared", 32'(errIrq), 0);
    chk(grantValid && grantChan == 7, "R7 grant held", 32'(grantChan), 7);

    serve(); serve(); serve();
    repeat (6) @(negedge clk);
    chk(grantValid === 1'b0, "R3 prio0 never granted", 32'(grantValid), 0);
    rdChk(A_PEND, 32'h1000, "R3 ch12 still pending");
    rdChk(A_INT, 32'h288, "R7 completion bits");
    chk(doneIrq === 1'b1, "R7 doneIrq", 32'(doneIrq), 1);
    wr(A_INT, 32'h200);
    rdChk(A_INT, 32'h88, "R8 int w1c");
    wr(A_PEND, 32'h1000);
    rdChk(A_PEND, 32'h0, "R8 pend w1c");

    // software path on ch5
    wr(7'h25, 1);
    expQ.push_back(5);
    wr(A_START, 32'h20);
    @(negedge clk);
    rdChk(A_START, 32'h20, "R6 start readback");
    chk(grantValid && grantChan == 5, "R6 sw grant", 32'(grantChan), 5);
    wr(A_START, 32'h20);
    rdChk(A_ERR, 32'h20, "R5 sw overflow");
    wr(A_HALT, 32'h20);
    @(negedge clk);
    chk(grantValid === 1'b0, "R9 grant withdrawn", 32'(grantValid), 0);
    rdChk(A_START, 32'h0, "R9 pending removed");
    rdChk(A_STOP, 32'h20, "R9 stop bit");
    wr(A_START, 32'h20);
    repeat (4) @(negedge clk);
    chk(grantValid === 1'b0, "R9 stopped not granted", 32'(grantValid), 0);
    expQ.push_back(5);
    wr(A_STOP, 32'h20);
    rdChk(A_STOP, 32'h0, "R8 stop w1c");
    serve();
    repeat (2) @(negedge clk);
    rdChk(A_START, 32'h0, "R7 done clears pending");
    rdChk(A_INT, 32'hA8, "R7 completion ch5");
    chk(expQ.size() == 0, "R4 all grants seen", 32'(expQ.size()), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule